// File: doc/BRIEF.md
# Byte and Word Load-Store Unit

This unit connects a core's load and store path to a 32-bit little-endian memory port. Each request carries four things: the access kind (word load, word store, byte load or byte store), a byte address, the store data, and the current value of the destination register. The unit registers the request and drives the memory port with four signals: a word address, a four-bit byte-enable strobe, lane-aligned write data, and a misalignment flag.

For a load, the memory returns the addressed word in the cycle that the port request is presented. The unit registers that word and, one cycle later, returns the value the core writes back. A word load returns the whole word. A byte load replaces only the low byte of the old destination value and keeps its upper 24 bits. A word access whose address is not word-aligned is forced to the aligned word and is flagged.

Top module: `lsu_unit`

## Requirements
- R1: While reset is asserted and after its release with no request, `mem_req_o`, `load_valid_o` and `misalign_o` are low.
- R2: A request sampled on a clock edge appears on the memory port after that edge: `mem_req_o` is high for exactly one cycle, and `mem_we_o` is 1 for the store codes (`op_i` 2'b01 word store, 2'b11 byte store) and 0 for the load codes (2'b00 word load, 2'b10 byte load).
- R3: `mem_addr_o` equals the request address with bits 1:0 cleared.
- R4: A word access drives `mem_be_o` = 4'b1111, and a word store drives `mem_wdata_o` equal to the store data.
- R5: `misalign_o` is high, together with `mem_req_o`, exactly for a word access whose address bits 1:0 are non-zero. It is low for byte accesses.
- R6: A byte access drives `mem_be_o` one-hot, with bit n set where n = address bits 1:0. Lane n covers data bits 8n+7:8n.
- R7: A byte store drives all four lanes of `mem_wdata_o` with bits 7:0 of the store data.
- R8: A word load raises `load_valid_o` for one cycle, one cycle after `mem_req_o`, with `load_data_o` equal to the memory word returned in the `mem_req_o` cycle.
- R9: A byte load returns `load_data_o` = {old destination bits 31:8, memory lane n byte}, where n = address bits 1:0. The old destination value is the one given with the request.
- R10: A store never raises `load_valid_o`. Cycles without a request leave `mem_req_o` low. Inputs that change after a request is captured do not alter that request's port values or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| op_i | input | 2 | Access kind: bit 1 selects byte, bit 0 selects store |
| addr_i | input | 32 | Byte address |
| store_data_i | input | 32 | Data to store |
| dest_old_i | input | 32 | Current destination register value |
| mem_rdata_i | input | 32 | Memory read word, valid while mem_req_o is high |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| misalign_o | output | 1 | Word access was not word-aligned |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Value to write back to the destination register |

## Verification
Byte loads and stores are driven on each of the four lane offsets. This shows that the lane selection follows the low address bits and is not hardwired. Byte loads use distinct old destination values and distinct memory words, so merging into the old upper bits is told apart from zero or sign extension and from taking the wrong lane. Word accesses are driven at all four offsets, which separates forced alignment and the flag from byte-style strobing. Random mixes with inputs scrambled after capture show that each result belongs to its own request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  function automatic logic op_is_byte(lsu_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_store(lsu_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/lsu_req_gen.sv
module lsu_req_gen #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  lsu_pkg::lsu_op_e         op_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [AW-1:0]            addr_w_o,
  output logic [DW/8-1:0]          be_o,
  output logic [DW-1:0]            wdata_o,
  output logic                     misalign_o,
  output logic                     we_o
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  logic             is_byte;
  logic [OFF_W-1:0] offset;

  assign is_byte    = lsu_pkg::op_is_byte(op_i);
  assign we_o       = lsu_pkg::op_is_store(op_i);
  assign offset     = addr_i[OFF_W-1:0];
  assign addr_w_o   = {addr_i[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign misalign_o = !is_byte && (offset != '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_o[g]          = is_byte ? (offset == OFF_W'(g)) : 1'b1;
    // byte stores replicate the low byte into every lane
    assign wdata_o[g*8 +: 8] = is_byte ? wdata_i[7:0] : wdata_i[g*8 +: 8];
  end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]             rdata_i,
  input  logic [$clog2(DW/8)-1:0]   lane_i,
  input  logic                      is_byte_i,
  input  logic [DW-1:0]             dest_old_i,
  output logic [DW-1:0]             result_o
);
  localparam int LANES = DW / 8;

  logic [7:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_bytes[g] = rdata_i[g*8 +: 8];
  end

  // byte load keeps the upper bits of the old destination
  assign result_o = is_byte_i ? {dest_old_i[DW-1:8], lane_bytes[lane_i]} : rdata_i;
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        op_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     store_data_i,
  input  logic [DW-1:0]     dest_old_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW/8-1:0]   mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              misalign_o,
  output logic              load_valid_o,
  output logic [DW-1:0]     load_data_o
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  lsu_pkg::lsu_op_e op;
  logic [AW-1:0]    addr_w;
  logic [LANES-1:0] be_d;
  logic [DW-1:0]    wdata_d;
  logic             misalign_d;
  logic             we_d;

  assign op = lsu_pkg::lsu_op_e'(op_i);

  lsu_req_gen #(.AW(AW), .DW(DW)) u_req_gen (
    .op_i       (op),
    .addr_i     (addr_i),
    .wdata_i    (store_data_i),
    .addr_w_o   (addr_w),
    .be_o       (be_d),
    .wdata_o    (wdata_d),
    .misalign_o (misalign_d),
    .we_o       (we_d)
  );

  // request stage
  logic              req_q, we_q, mis_q, byte_q;
  logic [AW-1:0]     addr_q;
  logic [LANES-1:0]  be_q;
  logic [DW-1:0]     wdata_q, dest_q;
  logic [OFF_W-1:0]  lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      mis_q   <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      dest_q  <= '0;
      lane_q  <= '0;
    end else begin
      req_q <= req_valid_i;
      mis_q <= req_valid_i && misalign_d;
      if (req_valid_i) begin
        we_q    <= we_d;
        byte_q  <= lsu_pkg::op_is_byte(op);
        addr_q  <= addr_w;
        be_q    <= be_d;
        wdata_q <= wdata_d;
        dest_q  <= dest_old_i;
        lane_q  <= addr_i[OFF_W-1:0];
      end
    end
  end

  // response stage
  logic [DW-1:0] merged;

  lsu_load_merge #(.DW(DW)) u_merge (
    .rdata_i    (mem_rdata_i),
    .lane_i     (lane_q),
    .is_byte_i  (byte_q),
    .dest_old_i (dest_q),
    .result_o   (merged)
  );

  logic          lv_q;
  logic [DW-1:0] ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q <= 1'b0;
      ld_q <= '0;
    end else begin
      lv_q <= req_q && !we_q;
      if (req_q && !we_q) ld_q <= merged;
    end
  end

  assign mem_req_o    = req_q;
  assign mem_we_o     = req_q && we_q;
  assign mem_addr_o   = addr_q;
  assign mem_be_o     = req_q ? be_q : '0;
  assign mem_wdata_o  = wdata_q;
  assign misalign_o   = mis_q;
  assign load_valid_o = lv_q;
  assign load_data_o  = ld_q;
endmodule

// File: rtl/lsu_unit_chk.sv
module lsu_unit_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DW/8-1:0]   mem_be_o,
  input logic              misalign_o,
  input logic              load_valid_o
);
  p_req_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> mem_req_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !mem_req_o);

  p_aligned_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_strobe_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || mem_be_o == '1));

  p_misalign_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_req_o && mem_be_o == '1));

  p_load_timing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o);

  p_store_no_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !load_valid_o);
endmodule

bind lsu_unit lsu_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/lsu_unit_test.sv
`timescale 1ns/1ps
module lsu_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] addr_i = '0, store_data_i = '0, dest_old_i = '0, mem_rdata_i = '0;
  logic        mem_req_o, mem_we_o, misalign_o, load_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [3:0]  mem_be_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  lsu_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .addr_i(addr_i), .store_data_i(store_data_i), .dest_old_i(dest_old_i),
    .mem_rdata_i(mem_rdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .misalign_o(misalign_o), .load_valid_o(load_valid_o), .load_data_o(load_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] op, input logic [31:0] a);
    return op[1] ? (4'b0001 << a[1:0]) : 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [1:0] op, input logic [31:0] d);
    return op[1] ? {4{d[7:0]}} : d;
  endfunction

  function automatic logic [31:0] exp_load(input logic [1:0] op, input logic [31:0] a,
                                           input logic [31:0] old, input logic [31:0] rd);
    return op[1] ? {old[31:8], rd[8*a[1:0] +: 8]} : rd;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] sd,
                        input logic [31:0] dold, input logic [31:0] rd);
    @(negedge clk);
    req_valid_i = 1'b1; op_i = op; addr_i = a; store_data_i = sd; dest_old_i = dold;
    @(negedge clk);
    req_valid_i = 1'b0;
    // scramble inputs after capture (R10)
    op_i = 2'($urandom); addr_i = $urandom; store_data_i = $urandom; dest_old_i = $urandom;
    chk("R2 mem_req", 32'(mem_req_o), 32'd1);
    chk("R2 mem_we", 32'(mem_we_o), 32'(op[0]));
    chk("R3 addr", mem_addr_o, {a[31:2], 2'b00});
    if (op[1]) chk("R6 byte strobe", 32'(mem_be_o), 32'(exp_be(op, a)));
    else       chk("R4 word strobe", 32'(mem_be_o), 32'(exp_be(op, a)));
    chk("R5 misalign", 32'(misalign_o), 32'(!op[1] && a[1:0] != 2'b00));
    if (op == 2'b11) chk("R7 byte wdata", mem_wdata_o, exp_wdata(op, sd));
    if (op == 2'b01) chk("R4 word wdata", mem_wdata_o, exp_wdata(op, sd));
    mem_rdata_i = rd;
    @(negedge clk);
    mem_rdata_i = $urandom;
    chk("R10 single req", 32'(mem_req_o), 32'd0);
    if (op[0]) chk("R10 store no load", 32'(load_valid_o), 32'd0);
    else begin
      chk("R8 load valid", 32'(load_valid_o), 32'd1);
      if (op[1]) chk("R9 byte merge", load_data_o, exp_load(op, a, dold, rd));
      else       chk("R8 word data", load_data_o, exp_load(op, a, dold, rd));
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 req in reset", 32'(mem_req_o), 32'd0);
    chk("R1 lv in reset", 32'(load_valid_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", 32'(mem_req_o), 32'd0);
    chk("R1 misalign after reset", 32'(misalign_o), 32'd0);
    chk("R1 lv after reset", 32'(load_valid_o), 32'd0);

    for (int k = 0; k < 4; k++) begin
      run_op(2'b10, 32'h0000_1000 + k, '0, 32'hCAFE_BA00 + k, 32'h4433_2211);
      run_op(2'b11, 32'h0000_2000 + k, 32'h1234_56A0 + k, '0, '0);
      run_op(2'b00, 32'h0000_3000 + k, '0, 32'h5555_5555, 32'hDEAD_BEEF);
      run_op(2'b01, 32'h0000_4000 + k, 32'h89AB_CDEF, '0, '0);
    end
    run_op(2'b10, 32'hFFFF_FFFF, '0, 32'hFFFF_FFFF, 32'h00FF_FFFF);
    run_op(2'b10, 32'h0, '0, 32'h8000_0000, 32'hFFFF_FF80);
    run_op(2'b00, 32'hFFFF_FFFE, '0, '0, 32'h8000_0001);

    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom), $urandom, $urandom, $urandom, $urandom);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk("R10 idle", 32'(mem_req_o), 32'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule